// File: doc/BRIEF.md
# Video-Mode Packet Sequencer

This block watches a parallel pixel interface (vertical sync, horizontal sync, data-enable and pixel words) and produces an ordered stream of packet descriptors for a serial display link. Each descriptor holds a 6-bit data type, a 2-bit virtual channel and a 16-bit word count. A later stage uses these descriptors to build headers and to distribute lanes. The pixel words of accepted active lines are passed on beside the descriptors as a payload stream.

Static configuration inputs select several things. The video mode chooses whether sync-end packets are sent. The blanking fill chooses whether porches are filled with blanking packets, null packets or nothing. The pixel format sets the pixel data type and the byte count. Further inputs set the sync input polarities, the horizontal sync width and the porch lengths, the vertical back porch, the number of active lines, and the largest pixel count per pixel packet. A small queue can accept several descriptors in one cycle and releases them one at a time over a valid/ready handshake.

Top module: `vid_pkt_seq`

## Requirements
- R1: After reset, `desc_valid_o` and `pix_valid_o` are low until the interface produces an event.
- R2: Bit 0 of `cfg_pol_i` selects the vertical sync polarity and bit 1 selects the horizontal sync polarity. A 1 means active high and a 0 means active low. Data-enable is always active high.
- R3: When vertical sync asserts, the block emits type 0x01. When horizontal sync asserts while vertical sync is inactive, it emits type 0x21. Sync packets carry word count 0.
- R4: With `cfg_mode_i` = 0 (sync pulses), type 0x31 is emitted exactly `cfg_hsw_i` clocks after each 0x21, and type 0x11 is emitted when vertical sync deasserts. With mode 1 (sync events) or mode 2 (burst), neither is emitted. A `cfg_hsw_i` of 0 gives no 0x31.
- R5: Each active line is cut into pixel packets of `cfg_max_pix_i` pixels. A shorter packet carries the remainder when data-enable falls. The pixel data type comes from `cfg_fmt_i`: 0 gives 0x0E, 1 gives 0x1E, 2 gives 0x2E and 3 gives 0x3E.
- R6: A pixel packet's word count is its pixel count n multiplied by 2 for format 0, by 3 for formats 2 and 3, and equal to floor(9n/4) for format 1.
- R7: `cfg_fill_i` = 1 fills with type 0x19, 2 fills with type 0x09, and 0 or 3 sends no fill. In modes 0 and 1, a fill with word count `cfg_hbp_i` comes before the first pixel packet of the line, and a fill with word count `cfg_hfp_i` comes after the last one.
- R8: In mode 2 there is no fill before the pixels. A single fill after the last pixel packet carries word count `cfg_hfp_i + cfg_hbp_i + cfg_hsw_i`.
- R9: Lines are counted by 0x21 events, starting again after each 0x01, and the first such line is line 1. Data-enable is accepted only on lines `cfg_vbp_i`+1 through `cfg_vbp_i`+`cfg_vact_i`. On any other line it produces no pixel packet, no fill and no payload.
- R10: Descriptors created in the same cycle are delivered in this order: vertical sync, horizontal sync, leading fill, pixel packet, trailing fill. While `desc_ready_i` is low, the head descriptor is held stable and nothing is lost.
- R11: Every descriptor carries `cfg_vc_i` as its virtual channel.
- R12: Accepted pixels appear on `pix_data_o` with `pix_valid_o` high, in input order, two clocks after they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Vertical sync, polarity per cfg_pol_i[0] |
| hsync_i | input | 1 | Horizontal sync, polarity per cfg_pol_i[1] |
| de_i | input | 1 | Data-enable, active high |
| pixel_i | input | PIX_W | Pixel word |
| cfg_mode_i | input | 2 | 0 sync pulses, 1 sync events, 2 burst |
| cfg_fill_i | input | 2 | 0 none, 1 blanking, 2 null |
| cfg_fmt_i | input | 2 | Pixel format code |
| cfg_pol_i | input | 2 | Sync polarity flags |
| cfg_vc_i | input | 2 | Virtual channel |
| cfg_hsw_i | input | H_W | Horizontal sync width, in clocks |
| cfg_hbp_i | input | H_W | Horizontal back porch, in clocks |
| cfg_hfp_i | input | H_W | Horizontal front porch, in clocks |
| cfg_vbp_i | input | V_W | Vertical back porch, in lines |
| cfg_vact_i | input | V_W | Active line count |
| cfg_max_pix_i | input | H_W | Maximum pixels per pixel packet |
| desc_valid_o | output | 1 | Descriptor available |
| desc_ready_i | input | 1 | Consumer accepts descriptor |
| desc_dt_o | output | 6 | Descriptor data type |
| desc_vc_o | output | 2 | Descriptor virtual channel |
| desc_wc_o | output | 16 | Descriptor word count |
| pix_valid_o | output | 1 | Payload pixel valid |
| pix_data_o | output | PIX_W | Payload pixel |

## Verification
Several descriptors can arise in the same cycle. When data-enable falls, the trailing partial pixel packet and the trailing fill are created together. With a packet size of one, the leading fill and the first pixel packet coincide. The bench also drops vertical sync in the very cycle that horizontal sync rises, so that the vertical-end and horizontal-start packets are created at the same edge. Each case is judged by comparing the full order of the delivered descriptor log with a list that the bench builds from the requirements.

// File: rtl/vid_pkt_pkg.sv
package vid_pkt_pkg;
  localparam int DT_W = 6;
  localparam int VC_W = 2;
  localparam int WC_W = 16;

  typedef struct packed {
    logic [DT_W-1:0] dt;
    logic [VC_W-1:0] vc;
    logic [WC_W-1:0] wc;
  } desc_t;

  localparam logic [DT_W-1:0] DT_VSS   = 6'h01;
  localparam logic [DT_W-1:0] DT_VSE   = 6'h11;
  localparam logic [DT_W-1:0] DT_HSS   = 6'h21;
  localparam logic [DT_W-1:0] DT_HSE   = 6'h31;
  localparam logic [DT_W-1:0] DT_BLANK = 6'h19;
  localparam logic [DT_W-1:0] DT_NULL  = 6'h09;

  function automatic logic [DT_W-1:0] pix_dt(input logic [1:0] fmt);
    case (fmt)
      2'd0:    return 6'h0E;
      2'd1:    return 6'h1E;
      2'd2:    return 6'h2E;
      default: return 6'h3E;
    endcase
  endfunction

  function automatic logic [WC_W-1:0] pix_bytes(input logic [WC_W-1:0] n, input logic [1:0] fmt);
    logic [WC_W+3:0] t;
    case (fmt)
      2'd0:    t = {4'b0, n} << 1;
      2'd1:    t = ({4'b0, n} * (WC_W+4)'(9)) >> 2;
      default: t = {4'b0, n} * (WC_W+4)'(3);
    endcase
    return t[WC_W-1:0];
  endfunction
endpackage

// File: rtl/vid_pkt_level.sv
module vid_pkt_level (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic act_high_i,
  output logic lvl_o,
  output logic prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o  <= 1'b0;
      prev_o <= 1'b0;
    end else begin
      lvl_o  <= act_high_i ? raw_i : ~raw_i;
      prev_o <= lvl_o;
    end
  end
endmodule

// File: rtl/vid_pkt_queue.sv
module vid_pkt_queue
  import vid_pkt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NS    = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NS-1:0]   push_i,
  input  desc_t [NS-1:0]  slot_i,
  input  logic            ready_i,
  output logic            valid_o,
  output desc_t           data_o
);
  localparam int AW = $clog2(DEPTH);

  desc_t          mem [DEPTH];
  logic [AW-1:0]  wr_q, rd_q;
  logic [AW:0]    cnt_q;
  logic [AW:0]    off [NS];
  logic [AW:0]    npush;
  logic           pop;
  logic [AW+1:0]  cnt_nxt;

  // slot i lands after every lower-numbered slot pushed in the same cycle
  always_comb begin
    off[0] = '0;
    for (int i = 1; i < NS; i++) off[i] = off[i-1] + {{AW{1'b0}}, push_i[i-1]};
    npush = off[NS-1] + {{AW{1'b0}}, push_i[NS-1]};
  end

  assign valid_o = (cnt_q != '0);
  assign data_o  = mem[rd_q];
  assign pop     = valid_o & ready_i;
  assign cnt_nxt = {1'b0, cnt_q} + {1'b0, npush} - {{(AW+1){1'b0}}, pop};

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < NS; i++)
      if (push_i[i]) mem[wr_q + off[i][AW-1:0]] <= slot_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_q + npush[AW-1:0];
      rd_q  <= rd_q + AW'(pop);
      cnt_q <= cnt_nxt[AW:0];
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_nxt <= (AW+2)'(DEPTH));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));
endmodule

// File: rtl/vid_pkt_seq.sv
module vid_pkt_seq
  import vid_pkt_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int H_W   = 12,
  parameter int V_W   = 12,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vsync_i,
  input  logic             hsync_i,
  input  logic             de_i,
  input  logic [PIX_W-1:0] pixel_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic [1:0]       cfg_fill_i,
  input  logic [1:0]       cfg_fmt_i,
  input  logic [1:0]       cfg_pol_i,
  input  logic [1:0]       cfg_vc_i,
  input  logic [H_W-1:0]   cfg_hsw_i,
  input  logic [H_W-1:0]   cfg_hbp_i,
  input  logic [H_W-1:0]   cfg_hfp_i,
  input  logic [V_W-1:0]   cfg_vbp_i,
  input  logic [V_W-1:0]   cfg_vact_i,
  input  logic [H_W-1:0]   cfg_max_pix_i,
  output logic             desc_valid_o,
  input  logic             desc_ready_i,
  output logic [5:0]       desc_dt_o,
  output logic [1:0]       desc_vc_o,
  output logic [15:0]      desc_wc_o,
  output logic             pix_valid_o,
  output logic [PIX_W-1:0] pix_data_o
);
  localparam int NSIG = 3;  // 0 vsync, 1 hsync, 2 data-enable
  localparam int NS   = 5;  // slots in delivery order
  localparam int S_V = 0, S_H = 1, S_FB = 2, S_PX = 3, S_FF = 4;

  logic [NSIG-1:0] raw, pol, lvl, prev;
  assign raw = {de_i, hsync_i, vsync_i};
  assign pol = {1'b1, cfg_pol_i[1], cfg_pol_i[0]};

  for (genvar g = 0; g < NSIG; g++) begin : g_lvl
    vid_pkt_level u_lvl (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(raw[g]), .act_high_i(pol[g]),
      .lvl_o(lvl[g]), .prev_o(prev[g])
    );
  end

  logic mode_pulse, burst, fill_en;
  assign mode_pulse = (cfg_mode_i == 2'd0);
  assign burst      = (cfg_mode_i == 2'd2);
  assign fill_en    = (cfg_fill_i == 2'd1) || (cfg_fill_i == 2'd2);

  logic vss, vse, hss, hse;
  logic [H_W-1:0] hcnt_q;
  assign vss = lvl[0] & ~prev[0];
  assign vse = ~lvl[0] & prev[0] & mode_pulse;
  assign hss = lvl[1] & ~prev[1] & ~lvl[0];
  assign hse = mode_pulse && (hcnt_q == H_W'(1)) && !hss;

  // vertical window
  logic [V_W-1:0] line_q;
  logic [V_W:0]   win_lo, win_hi;
  logic           win;
  assign win_lo = {1'b0, cfg_vbp_i};
  assign win_hi = win_lo + {1'b0, cfg_vact_i};
  assign win    = ({1'b0, line_q} > win_lo) && ({1'b0, line_q} <= win_hi);

  logic de_on, de_rise, de_fall;
  assign de_on   = lvl[2] & win;
  assign de_rise = lvl[2] & ~prev[2] & win;
  assign de_fall = ~lvl[2] & prev[2] & win;

  // packet splitting
  logic [H_W-1:0] pcnt_q, px_n;
  logic [H_W:0]   pnext;
  logic           px_full, px_emit;
  assign pnext   = {1'b0, pcnt_q} + (H_W+1)'(1);
  assign px_full = de_on && (pnext == {1'b0, cfg_max_pix_i});
  assign px_emit = px_full || (de_fall && (pcnt_q != '0));
  assign px_n    = px_full ? cfg_max_pix_i : pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      line_q <= '0;
      pcnt_q <= '0;
    end else begin
      if (hss)                 hcnt_q <= cfg_hsw_i;
      else if (hcnt_q != '0)   hcnt_q <= hcnt_q - H_W'(1);
      if (vss)                 line_q <= '0;
      else if (hss)            line_q <= line_q + V_W'(1);
      if (hss || de_fall || px_full) pcnt_q <= '0;
      else if (de_on)          pcnt_q <= pnext[H_W-1:0];
    end
  end

  logic [DT_W-1:0] fill_dt;
  logic [WC_W-1:0] ff_wc;
  assign fill_dt = (cfg_fill_i == 2'd1) ? DT_BLANK : DT_NULL;
  assign ff_wc   = burst ? (WC_W'(cfg_hfp_i) + WC_W'(cfg_hbp_i) + WC_W'(cfg_hsw_i))
                         : WC_W'(cfg_hfp_i);

  logic [NS-1:0]  push;
  desc_t [NS-1:0] slot;
  always_comb begin
    push[S_V]  = vss | vse;
    push[S_H]  = hss | hse;
    push[S_FB] = de_rise & fill_en & ~burst;
    push[S_PX] = px_emit;
    push[S_FF] = de_fall & fill_en;
    slot[S_V]  = '{dt: vss ? DT_VSS : DT_VSE, vc: cfg_vc_i, wc: '0};
    slot[S_H]  = '{dt: hss ? DT_HSS : DT_HSE, vc: cfg_vc_i, wc: '0};
    slot[S_FB] = '{dt: fill_dt, vc: cfg_vc_i, wc: WC_W'(cfg_hbp_i)};
    slot[S_PX] = '{dt: pix_dt(cfg_fmt_i), vc: cfg_vc_i,
                   wc: pix_bytes(WC_W'(px_n), cfg_fmt_i)};
    slot[S_FF] = '{dt: fill_dt, vc: cfg_vc_i, wc: ff_wc};
  end

  desc_t head;
  vid_pkt_queue #(.DEPTH(DEPTH), .NS(NS)) u_queue (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .slot_i(slot),
    .ready_i(desc_ready_i), .valid_o(desc_valid_o), .data_o(head)
  );
  assign desc_dt_o = head.dt;
  assign desc_vc_o = head.vc;
  assign desc_wc_o = head.wc;

  // payload, aligned with the sampled data-enable
  logic [PIX_W-1:0] pix_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q       <= '0;
      pix_data_o  <= '0;
      pix_valid_o <= 1'b0;
    end else begin
      pix_q       <= pixel_i;
      pix_data_o  <= pix_q;
      pix_valid_o <= de_on;
    end
  end

  a_r3_hss_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hss |=> !hss);

  a_r3_short_wc_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && (desc_dt_o == DT_VSS || desc_dt_o == DT_VSE ||
                     desc_dt_o == DT_HSS || desc_dt_o == DT_HSE) |-> desc_wc_o == '0);

  a_r5_pix_wc_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && (desc_dt_o[3:0] == 4'hE) |-> desc_wc_o != '0);

  a_r4_hse_after_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push[S_H] && !hss |-> mode_pulse);
endmodule

// File: tb/vid_pkt_seq_test.sv
`timescale 1ns/1ps
module vid_pkt_seq_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic vsync = 1'b1, hsync = 1'b1, de = 1'b0;
  logic [23:0] pixel = '0;
  logic [1:0] mode = 0, fill = 0, fmt = 0, pol = 0, vc = 0;
  logic [11:0] hsw = 3, hbp = 4, hfp = 5, vbp = 0, vact = 4, maxpix = 4;
  logic ready = 1'b1;
  logic dv, pv;
  logic [5:0] ddt;
  logic [1:0] dvc;
  logic [15:0] dwc;
  logic [23:0] pd;

  vid_pkt_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync), .hsync_i(hsync), .de_i(de), .pixel_i(pixel),
    .cfg_mode_i(mode), .cfg_fill_i(fill), .cfg_fmt_i(fmt), .cfg_pol_i(pol), .cfg_vc_i(vc),
    .cfg_hsw_i(hsw), .cfg_hbp_i(hbp), .cfg_hfp_i(hfp), .cfg_vbp_i(vbp), .cfg_vact_i(vact),
    .cfg_max_pix_i(maxpix), .desc_valid_o(dv), .desc_ready_i(ready), .desc_dt_o(ddt),
    .desc_vc_o(dvc), .desc_wc_o(dwc), .pix_valid_o(pv), .pix_data_o(pd)
  );

  int n_chk = 0, n_err = 0;
  logic [5:0]  got_dt [256];
  logic [1:0]  got_vc [256];
  logic [15:0] got_wc [256];
  logic [5:0]  exp_dt [256];
  logic [15:0] exp_wc [256];
  logic [23:0] got_px [256];
  logic [23:0] exp_px [256];
  int n_got = 0, n_exp = 0, n_gpx = 0, n_epx = 0;

  always @(negedge clk) if (rst_n) begin
    if (dv && ready && n_got < 256) begin
      got_dt[n_got] = ddt; got_vc[n_got] = dvc; got_wc[n_got] = dwc; n_got++;
    end
    if (pv && n_gpx < 256) begin got_px[n_gpx] = pd; n_gpx++; end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  function automatic logic lv(input bit act, input bit hi);
    return hi ? act : !act;
  endfunction

  task automatic idle_levels;
    vsync = lv(0, pol[0]); hsync = lv(0, pol[1]); de = 1'b0;
  endtask

  function automatic int nbytes(input int n);
    case (fmt)
      2'd0: return n * 2;
      2'd1: return (n * 9) / 4;
      default: return n * 3;
    endcase
  endfunction

  task automatic epush(input logic [5:0] dt, input int wc);
    exp_dt[n_exp] = dt; exp_wc[n_exp] = 16'(wc); n_exp++;
  endtask

  task automatic exp_vpulse;
    epush(6'h01, 0);
    if (mode == 0) epush(6'h11, 0);
  endtask

  task automatic exp_body(input int n, input bit act, input int base);
    logic [5:0] fdt;
    int rem;
    fdt = (fill == 1) ? 6'h19 : 6'h09;
    if (act && n > 0) begin
      if ((fill == 1 || fill == 2) && mode != 2) epush(fdt, hbp);
      rem = n;
      while (rem > 0) begin
        int c;
        c = (rem > maxpix) ? int'(maxpix) : rem;
        epush(6'h0E + {fmt, 4'h0}, nbytes(c));
        rem -= c;
      end
      if (fill == 1 || fill == 2) epush(fdt, (mode == 2) ? hfp + hbp + hsw : int'(hfp));
      for (int k = 0; k < n; k++) begin exp_px[n_epx] = 24'(base + k); n_epx++; end
    end
  endtask

  task automatic exp_line(input int n, input bit act, input int base);
    epush(6'h21, 0);
    if (mode == 0 && hsw != 0) epush(6'h31, 0);
    exp_body(n, act, base);
  endtask

  task automatic vpulse;
    vsync = lv(1, pol[0]); tick(3);
    vsync = lv(0, pol[0]); tick(3);
  endtask

  task automatic body(input int n, input int base);
    tick(7);
    for (int k = 0; k < n; k++) begin de = 1'b1; pixel = 24'(base + k); tick(); end
    de = 1'b0; tick(5);
  endtask

  task automatic line(input int n, input int base);
    hsync = lv(1, pol[1]); tick(2);
    hsync = lv(0, pol[1]);
    body(n, base);
  endtask

  task automatic compare(input string req);
    tick(40);
    check(n_got == n_exp, {req, " descriptor count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check(got_dt[i] == exp_dt[i], {req, " data type"}, got_dt[i], exp_dt[i]);
      check(got_wc[i] == exp_wc[i], {req, " word count"}, got_wc[i], exp_wc[i]);
      check(got_vc[i] == vc, "R11 virtual channel", got_vc[i], vc);
    end
    check(n_gpx == n_epx, "R12 payload count", n_gpx, n_epx);
    for (int i = 0; i < n_epx && i < n_gpx; i++)
      check(got_px[i] == exp_px[i], "R12 payload word", got_px[i], exp_px[i]);
    n_got = 0; n_exp = 0; n_gpx = 0; n_epx = 0;
  endtask

  // R1
  task automatic t_reset;
    check(dv == 1'b0, "R1 desc_valid after reset", dv, 0);
    check(pv == 1'b0, "R1 pix_valid after reset", pv, 0);
  endtask

  // R2 (active low) R3 R4 R5 R6 R7 R9: pulse mode, blanking fill, window
  task automatic t_pulse_window;
    mode = 0; fill = 1; fmt = 3; vc = 1; vbp = 1; vact = 2; maxpix = 4;
    vpulse(); exp_vpulse();
    line(8, 16'h100); exp_line(8, 0, 16'h100);
    line(8, 16'h200); exp_line(8, 1, 16'h200);
    line(6, 16'h300); exp_line(6, 1, 16'h300);
    line(8, 16'h400); exp_line(8, 0, 16'h400);
    compare("R3 R4 R7 R9 pulse mode");
  endtask

  // R2 (active high) R4 (events) R5 R6 R7 null fill
  task automatic t_events_null;
    pol = 2'b11; idle_levels();
    mode = 1; fill = 2; fmt = 0; vc = 2; vbp = 0; vact = 4; maxpix = 3;
    tick(4);
    vpulse(); exp_vpulse();
    line(7, 16'h500); exp_line(7, 1, 16'h500);
    compare("R2 R4 R5 R6 events mode");
  endtask

  // R8 burst, R2 mixed polarity, R6 packed format, R7 no fill
  task automatic t_burst;
    pol = 2'b01; idle_levels();
    mode = 2; fill = 1; fmt = 1; vc = 3; maxpix = 4;
    tick(4);
    vpulse(); exp_vpulse();
    line(8, 16'h600); exp_line(8, 1, 16'h600);
    fill = 0;
    line(5, 16'h700); exp_line(5, 1, 16'h700);
    compare("R8 R6 burst mode");
  endtask

  // R10: vertical end and horizontal start in one cycle; fill and pixel in one cycle
  task automatic t_collide;
    pol = 2'b00; idle_levels();
    mode = 0; fill = 1; fmt = 2; vc = 0; maxpix = 1;
    tick(4);
    vsync = lv(1, 0); tick(3);
    vsync = lv(0, 0); hsync = lv(1, 0); tick(2);
    hsync = lv(0, 0);
    body(3, 16'h800);
    epush(6'h01, 0); epush(6'h11, 0);
    exp_line(3, 1, 16'h800);
    compare("R10 same-cycle order");
  endtask

  // R10 backpressure
  task automatic t_stall;
    logic [5:0] dt0;
    mode = 0; fill = 1; fmt = 3; vc = 1; maxpix = 4;
    vpulse(); exp_vpulse();
    tick(6);
    ready = 1'b0;
    line(8, 16'h900); exp_line(8, 1, 16'h900);
    check(dv == 1'b1, "R10 valid held while stalled", dv, 1);
    check(ddt == 6'h21, "R10 head is horizontal start", ddt, 6'h21);
    dt0 = ddt;
    tick(5);
    check(ddt == dt0 && dv, "R10 head stable", ddt, dt0);
    ready = 1'b1;
    compare("R10 backpressure");
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_pulse_window();
    t_events_null();
    t_burst();
    t_collide();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule